// File: doc/BRIEF.md
# Level-Priority Interrupt Arbitration Controller

This block gathers up to 64 interrupt request lines and decides which one is presented to a processor core. Each line has its own control register. The register holds an interrupt level, a priority inside that level, and a trigger mode (level-sensitive or edge-latched). A line whose level field is zero is switched off. The block keeps a pending bit for each line. From the enabled pending lines it picks the highest level, and then the highest priority inside that level. It raises an interrupt request to the core with that level when the level clears the core's current mask.

The contest is modelled as a wired-OR bus that is resolved one bit at a time, starting at the most significant bit. The source number of the winner is not arbitrated. It is the OR of the numbers of every line still in the contest. So when software wrongly gives two enabled lines the same level and the same priority, the core receives a merged source number, exactly as such a bus behaves in silicon.

When the core acknowledges, the block returns an 8-bit vector one cycle later, equal to the source number plus 64. It returns the spurious vector 24 when no enabled line was pending. It also returns the 32-bit exception stack-frame word that carries this vector.

Top module: `intc_lvlprio_ctrl`

## Requirements
- R1: On an acknowledge with a winner, `ack_valid` is high in the following cycle and `ack_vector` equals the winning source number plus 64 (source 5 gives 69, source 20 gives 84, source 53 gives 117).
- R2: After reset, `irq_req`, `irq_level` and `ack_valid` are 0 and every control register is zero. A line whose level field is 0 never takes part in the contest, whatever its request input does.
- R3: Among enabled pending lines, the numerically highest level wins. `irq_level` shows that level (0 when nothing is pending), combinationally from the pending and control state.
- R4: Among enabled pending lines at the winning level, the numerically highest priority wins, and only that line's vector is returned.
- R5: When two or more enabled pending lines share the winning level and the winning priority, the returned source number is the bitwise OR of their numbers (13 with 53 gives 61, vector 125). Changing the level or the priority of one of them removes the merge.
- R6: `irq_req` is high only when the winning level is greater than `ipl_mask`, or when the winning level is 7, which cannot be masked.
- R7: In level mode (`cfg_edge` = 0), a line's pending bit equals its request input at the previous clock edge. An acknowledge does not clear it.
- R8: In edge mode (`cfg_edge` = 1), a rising request edge sets the pending bit. The bit then stays set until `clr_wr` selects that line. A rising edge in the same cycle as a clear leaves the bit set.
- R9: An acknowledge taken while no enabled line is pending returns vector 24.
- R10: `frame_word` has the format value 4 in bits 31:28, the returned vector in bits 25:18, `status_word` (sampled at the acknowledge) in bits 15:0, and zeros elsewhere (vector 0x7D with status 0x2004 gives 0x41F42004).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 64 | Interrupt request lines, bit n is source n |
| cfg_wr | input | 1 | Write strobe for a line's control register |
| cfg_sel | input | 6 | Line whose control register is written |
| cfg_edge | input | 1 | Trigger mode written: 0 level, 1 edge |
| cfg_level | input | 3 | Level written (0 switches the line off) |
| cfg_prio | input | 3 | Priority within the level written |
| clr_wr | input | 1 | Clear strobe for an edge-mode pending bit |
| clr_sel | input | 6 | Line whose pending bit is cleared |
| ipl_mask | input | 3 | Core's current interrupt priority mask |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | 3 | Level of the current winner |
| ack_strobe | input | 1 | Interrupt acknowledge from the core |
| status_word | input | 16 | Core status placed in the frame word |
| ack_valid | output | 1 | Vector and frame word are valid |
| ack_vector | output | 8 | Returned vector number |
| frame_word | output | 32 | Exception stack-frame format word |

## Verification
The assertions take for granted that reset is applied before use. The pending-tracking checks also wait one clock after reset, so the previous request sample they look at is a real one. `cfg_sel` and `clr_sel` are assumed to address existing lines, which holds at the default width because every 6-bit code names a line. The bench drives each input once per cycle, well away from the sampling edge. Its random phase writes control registers from a small pool of levels and priorities, so misconfigured ties (and therefore merged vectors) occur often, next to clean configurations.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  // vector number returned to the core for a merged or single source number
  function automatic logic [7:0] src_to_vec(input logic [7:0] src_id,
                                            input logic [7:0] base);
    return src_id + base;
  endfunction

  // exception stack-frame word: format nibble, vector in 25:18, status in 15:0
  function automatic logic [31:0] build_frame(input logic [3:0]  fmt,
                                              input logic [7:0]  vec,
                                              input logic [15:0] sr);
    return {fmt, 2'b00, vec, 2'b00, sr};
  endfunction

endpackage

// File: rtl/intc_cfg_bank.sv
module intc_cfg_bank
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = 6,
  parameter int LVL_W   = 3,
  parameter int PRI_W   = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ID_W-1:0]                   wr_sel,
  input  logic                              wr_edge,
  input  logic [LVL_W-1:0]                  wr_level,
  input  logic [PRI_W-1:0]                  wr_prio,
  output logic [NUM_SRC-1:0][LVL_W-1:0]     lvl_o,
  output logic [NUM_SRC-1:0][PRI_W-1:0]     pri_o,
  output logic [NUM_SRC-1:0]                edge_o,
  output logic [NUM_SRC-1:0]                en_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_reg
    logic [LVL_W-1:0] lvl_q;
    logic [PRI_W-1:0] pri_q;
    trig_e            trig_q;
    logic             hit;

    assign hit = wr_en && (wr_sel == ID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q  <= '0;
        pri_q  <= '0;
        trig_q <= TRIG_LEVEL;
      end else if (hit) begin
        lvl_q  <= wr_level;
        pri_q  <= wr_prio;
        trig_q <= wr_edge ? TRIG_EDGE : TRIG_LEVEL;
      end
    end

    assign lvl_o[g]  = lvl_q;
    assign pri_o[g]  = pri_q;
    assign edge_o[g] = (trig_q == TRIG_EDGE);
    // a zero level is the reset value and keeps the line out of the contest
    assign en_o[g]   = |lvl_q;
  end

endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] edge_mask,
  input  logic               clr_en,
  input  logic [ID_W-1:0]    clr_sel,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] req_prev_q;
  logic [NUM_SRC-1:0] rise_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] pend_d;
  logic               seen_q;

  assign rise_vec = src_req & ~req_prev_q;

  always_comb begin
    clr_vec = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      clr_vec[s] = clr_en && (clr_sel == ID_W'(s));
    end
  end

  // edge lines: hold until cleared, a new rising edge wins over the clear
  // level lines: follow the request
  assign pend_d = ((((pend_q & ~clr_vec) | rise_vec)) & edge_mask)
                | (src_req & ~edge_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      req_prev_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      req_prev_q <= src_req;
      seen_q     <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    ((pend_q ^ $past(src_req)) & ~$past(edge_mask)) == '0); // R7

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (($past(pend_q) & $past(edge_mask) & ~$past(clr_vec)) & ~pend_q) == '0); // R8

  AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (($past(src_req) & ~$past(req_prev_q) & $past(edge_mask)) & ~pend_q) == '0); // R8

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = 6,
  parameter int LVL_W   = 3,
  parameter int PRI_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0]            en_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [NUM_SRC-1:0][PRI_W-1:0] pri_i,
  output logic                          win_any,
  output logic [LVL_W-1:0]              win_level,
  output logic [PRI_W-1:0]              win_prio,
  output logic [ID_W-1:0]               win_id,
  output logic [NUM_SRC-1:0]            survivors,
  output logic                          merged
);

  // contenders left after each bit of the wired-OR contest
  logic [LVL_W:0][NUM_SRC-1:0] lvl_stage;
  logic [PRI_W:0][NUM_SRC-1:0] pri_stage;

  assign lvl_stage[0] = pend_i & en_i;

  for (genvar k = 0; k < LVL_W; k++) begin : g_lvl_bit
    logic [NUM_SRC-1:0] col;
    logic               hit;
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++) col[s] = lvl_i[s][LVL_W-1-k];
    end
    assign hit                = |(lvl_stage[k] & col);
    assign lvl_stage[k+1]     = hit ? (lvl_stage[k] & col) : lvl_stage[k];
    assign win_level[LVL_W-1-k] = hit;
  end

  assign pri_stage[0] = lvl_stage[LVL_W];

  for (genvar k = 0; k < PRI_W; k++) begin : g_pri_bit
    logic [NUM_SRC-1:0] col;
    logic               hit;
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++) col[s] = pri_i[s][PRI_W-1-k];
    end
    assign hit                 = |(pri_stage[k] & col);
    assign pri_stage[k+1]      = hit ? (pri_stage[k] & col) : pri_stage[k];
    assign win_prio[PRI_W-1-k] = hit;
  end

  assign survivors = pri_stage[PRI_W];
  assign win_any   = |lvl_stage[0];

  // the source number is not contested: every survivor drives its number onto the bus
  always_comb begin
    win_id = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (survivors[s]) win_id = win_id | ID_W'(s);
    end
  end

  assign merged = ($countones(survivors) > 1);

  AST_SURV_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> (survivors != '0)); // R4

  AST_DISABLED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (survivors & ~en_i) == '0); // R2

  AST_SINGLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(survivors) == 1) |-> (lvl_i[win_id] == win_level)); // R3

  AST_SINGLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(survivors) == 1) |-> (pri_i[win_id] == win_prio)); // R4

endmodule

// File: rtl/intc_lvlprio_ctrl.sv
module intc_lvlprio_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int LVL_W     = 3,
  parameter int PRI_W     = 3,
  parameter int VEC_BASE  = 64,
  parameter int SPUR_VEC  = 24,
  parameter int FRAME_FMT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_req,
  input  logic                     cfg_wr,
  input  logic [$clog2(NUM_SRC)-1:0] cfg_sel,
  input  logic                     cfg_edge,
  input  logic [LVL_W-1:0]         cfg_level,
  input  logic [PRI_W-1:0]         cfg_prio,
  input  logic                     clr_wr,
  input  logic [$clog2(NUM_SRC)-1:0] clr_sel,
  input  logic [LVL_W-1:0]         ipl_mask,
  output logic                     irq_req,
  output logic [LVL_W-1:0]         irq_level,
  input  logic                     ack_strobe,
  input  logic [15:0]              status_word,
  output logic                     ack_valid,
  output logic [7:0]               ack_vector,
  output logic [31:0]              frame_word
);

  localparam int ID_W = $clog2(NUM_SRC);
  localparam logic [LVL_W-1:0] NMI_LVL = {LVL_W{1'b1}};

  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_tab;
  logic [NUM_SRC-1:0][PRI_W-1:0] pri_tab;
  logic [NUM_SRC-1:0]            edge_mask;
  logic [NUM_SRC-1:0]            en_mask;
  logic [NUM_SRC-1:0]            pend;
  logic [NUM_SRC-1:0]            survivors;
  logic                          win_any;
  logic [LVL_W-1:0]              win_level;
  logic [PRI_W-1:0]              win_prio;
  logic [ID_W-1:0]               win_id;
  logic                          merged;
  logic [7:0]                    next_vec;
  logic                          ack_valid_q;
  logic [7:0]                    ack_vec_q;
  logic [31:0]                   frame_q;

  // a level reaches the core when above the mask, or when it is the top level
  function automatic logic level_passes(input logic [LVL_W-1:0] lvl,
                                        input logic [LVL_W-1:0] mask);
    return (lvl != '0) && ((lvl > mask) || (lvl == NMI_LVL));
  endfunction

  intc_cfg_bank #(
    .NUM_SRC(NUM_SRC), .ID_W(ID_W), .LVL_W(LVL_W), .PRI_W(PRI_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_sel   (cfg_sel),
    .wr_edge  (cfg_edge),
    .wr_level (cfg_level),
    .wr_prio  (cfg_prio),
    .lvl_o    (lvl_tab),
    .pri_o    (pri_tab),
    .edge_o   (edge_mask),
    .en_o     (en_mask)
  );

  intc_pending #(
    .NUM_SRC(NUM_SRC), .ID_W(ID_W)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .edge_mask (edge_mask),
    .clr_en    (clr_wr),
    .clr_sel   (clr_sel),
    .pend_o    (pend)
  );

  intc_arbiter #(
    .NUM_SRC(NUM_SRC), .ID_W(ID_W), .LVL_W(LVL_W), .PRI_W(PRI_W)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .en_i      (en_mask),
    .lvl_i     (lvl_tab),
    .pri_i     (pri_tab),
    .win_any   (win_any),
    .win_level (win_level),
    .win_prio  (win_prio),
    .win_id    (win_id),
    .survivors (survivors),
    .merged    (merged)
  );

  assign irq_level = win_level;
  assign irq_req   = level_passes(win_level, ipl_mask);

  assign next_vec = win_any ? src_to_vec(8'(win_id), 8'(VEC_BASE)) : 8'(SPUR_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_q <= 1'b0;
      ack_vec_q   <= '0;
      frame_q     <= '0;
    end else begin
      ack_valid_q <= ack_strobe;
      if (ack_strobe) begin
        ack_vec_q <= next_vec;
        frame_q   <= build_frame(4'(FRAME_FMT), next_vec, status_word);
      end
    end
  end

  assign ack_valid  = ack_valid_q;
  assign ack_vector = ack_vec_q;
  assign frame_word = frame_q;

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((irq_level > ipl_mask) || (irq_level == NMI_LVL))); // R6

  AST_NMI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_any && (irq_level == NMI_LVL)) |-> irq_req); // R6

  AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_strobe) && !$past(win_any)) |-> (ack_valid && ack_vector == 8'(SPUR_VEC))); // R9

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_strobe) && $past(win_any)) |-> (ack_valid && ack_vector >= 8'(VEC_BASE))); // R1

  AST_MERGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_strobe) && $past(win_any) && !$past(merged))
      |-> $past(survivors[win_id])); // R5

  AST_FRAME_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (frame_word[25:18] == ack_vector)); // R10

endmodule

// File: tb/test_intc_lvlprio_ctrl.sv
`timescale 1ns/1ps
module test_intc_lvlprio_ctrl;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_req = '0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_sel = '0;
  logic        cfg_edge = 1'b0;
  logic [2:0]  cfg_level = '0;
  logic [2:0]  cfg_prio = '0;
  logic        clr_wr = 1'b0;
  logic [5:0]  clr_sel = '0;
  logic [2:0]  ipl_mask = '0;
  logic        irq_req;
  logic [2:0]  irq_level;
  logic        ack_strobe = 1'b0;
  logic [15:0] status_word = '0;
  logic        ack_valid;
  logic [7:0]  ack_vector;
  logic [31:0] frame_word;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc_lvlprio_ctrl i_intc_lvlprio_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_edge(cfg_edge),
    .cfg_level(cfg_level), .cfg_prio(cfg_prio),
    .clr_wr(clr_wr), .clr_sel(clr_sel), .ipl_mask(ipl_mask),
    .irq_req(irq_req), .irq_level(irq_level),
    .ack_strobe(ack_strobe), .status_word(status_word),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .frame_word(frame_word)
  );

  // ---------------- reference model ----------------
  int m_lvl [N];
  int m_pri [N];
  bit m_edge[N];
  bit m_pend[N];
  bit m_prev[N];
  bit m_ack_valid;
  int m_ack_vec;
  longint m_frame;

  task automatic model_pick(output int lvl, output int vec);
    int best_l, best_p, id_or;
    best_l = 0; best_p = -1; id_or = 0;
    foreach (m_pend[i]) if (m_pend[i] && m_lvl[i] != 0 && m_lvl[i] > best_l) best_l = m_lvl[i];
    foreach (m_pend[i]) if (m_pend[i] && m_lvl[i] != 0 && m_lvl[i] == best_l && m_pri[i] > best_p) best_p = m_pri[i];
    foreach (m_pend[i]) if (m_pend[i] && m_lvl[i] != 0 && m_lvl[i] == best_l && m_pri[i] == best_p) id_or = id_or | i;
    lvl = best_l;
    vec = (best_l == 0) ? 24 : 64 + id_or;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lvl[i]) begin
        m_lvl[i] = 0; m_pri[i] = 0; m_edge[i] = 0; m_pend[i] = 0; m_prev[i] = 0;
      end
      m_ack_valid = 0; m_ack_vec = 0; m_frame = 0;
    end else begin
      int l, v;
      model_pick(l, v);
      m_ack_valid = ack_strobe;
      if (ack_strobe) begin
        m_ack_vec = v;
        m_frame   = (longint'(4) << 28) + (longint'(v) << 18) + longint'(status_word);
      end
      foreach (m_pend[i]) begin
        if (m_edge[i]) begin
          if (src_req[i] && !m_prev[i]) m_pend[i] = 1;
          else if (clr_wr && clr_sel == i) m_pend[i] = 0;
        end else begin
          m_pend[i] = src_req[i];
        end
        m_prev[i] = src_req[i];
      end
      if (cfg_wr) begin
        m_lvl[cfg_sel]  = cfg_level;
        m_pri[cfg_sel]  = cfg_prio;
        m_edge[cfg_sel] = cfg_edge;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int l, v;
      bit exp_req;
      model_pick(l, v);
      exp_req = (l != 0) && (l > ipl_mask || l == 7);
      chk("R6 irq_req", irq_req, exp_req);
      chk("R3 irq_level", irq_level, l);
      chk("R1 ack_valid", ack_valid, m_ack_valid);
      if (m_ack_valid) begin
        chk("R1/R5 ack_vector", ack_vector, m_ack_vec);
        chk("R10 frame_word", frame_word, m_frame);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr_cfg(input int id, input bit e, input int lv, input int pr);
    cfg_wr = 1; cfg_sel = 6'(id); cfg_edge = e; cfg_level = 3'(lv); cfg_prio = 3'(pr);
    cyc();
    cfg_wr = 0;
  endtask

  task automatic do_ack(input logic [15:0] sr);
    ack_strobe = 1; status_word = sr;
    cyc();
    ack_strobe = 0;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R2 reset irq_req", irq_req, 0);
    chk("R2 reset irq_level", irq_level, 0);
    chk("R2 reset ack_valid", ack_valid, 0);

    // unconfigured line has no effect; ack returns spurious
    src_req[10] = 1; cyc(); @(negedge clk);
    chk("R2 disabled line irq_req", irq_req, 0);
    do_ack(16'h0);
    chk("R9 spurious vector", ack_vector, 24);
    src_req[10] = 0;

    // single level-mode source
    wr_cfg(5, 0, 3, 2);
    src_req[5] = 1; cyc(); @(negedge clk);
    chk("R7 pending follows request", irq_level, 3);
    do_ack(16'h0);
    chk("R1 vector of source 5", ack_vector, 69);
    cyc(); @(negedge clk);
    chk("R7 ack leaves level line pending", irq_req, 1);
    src_req[5] = 0; cyc(); @(negedge clk);
    chk("R7 pending drops with request", irq_req, 0);

    // level order and masking
    wr_cfg(20, 0, 5, 1);
    src_req[5] = 1; src_req[20] = 1; cyc(); @(negedge clk);
    chk("R3 higher level wins", irq_level, 5);
    do_ack(16'h0);
    chk("R3 vector of source 20", ack_vector, 84);
    ipl_mask = 5; cyc(); @(negedge clk);
    chk("R6 level equal to mask blocked", irq_req, 0);
    ipl_mask = 4; cyc(); @(negedge clk);
    chk("R6 level above mask passes", irq_req, 1);
    wr_cfg(40, 0, 7, 0);
    ipl_mask = 7; src_req[40] = 1; cyc(); @(negedge clk);
    chk("R6 level 7 unmaskable", irq_req, 1);
    src_req[40] = 0; cyc(); @(negedge clk);
    chk("R6 level 5 under mask 7", irq_req, 0);
    ipl_mask = 0; src_req = '0;

    // priority within a level, ties, and merge removal
    wr_cfg(13, 0, 4, 3);
    wr_cfg(53, 0, 4, 5);
    src_req[13] = 1; src_req[53] = 1; cyc();
    do_ack(16'h0);
    chk("R4 higher priority wins", ack_vector, 117);
    wr_cfg(13, 0, 4, 5);
    do_ack(16'h2004);
    chk("R5 tied sources merge", ack_vector, 125);
    chk("R10 frame word", frame_word, 32'h41F4_2004);
    wr_cfg(13, 0, 3, 5);
    do_ack(16'h0);
    chk("R5 different level no merge", ack_vector, 117);
    src_req = '0;

    // edge mode
    wr_cfg(30, 1, 6, 0);
    src_req[30] = 1; cyc(); src_req[30] = 0; cyc(); @(negedge clk);
    chk("R8 edge pending held", irq_level, 6);
    clr_wr = 1; clr_sel = 30; cyc(); clr_wr = 0; @(negedge clk);
    chk("R8 clear drops pending", irq_req, 0);
    src_req[30] = 1; clr_wr = 1; clr_sel = 30; cyc(); clr_wr = 0; @(negedge clk);
    chk("R8 edge wins over clear", irq_level, 6);
    clr_wr = 1; cyc(); clr_wr = 0; @(negedge clk);
    chk("R8 clear with request held high", irq_req, 0);
    src_req = '0; cyc();

    // random phase with a small pool of levels and priorities
    for (int t = 0; t < 3000; t++) begin
      src_req  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      cfg_wr   = ($urandom % 4) == 0;
      cfg_sel  = 6'($urandom);
      cfg_edge = ($urandom % 3) == 0;
      cfg_level = 3'($urandom % 8);
      cfg_prio  = 3'($urandom % 3);
      clr_wr   = ($urandom % 3) == 0;
      clr_sel  = 6'($urandom);
      ipl_mask = 3'($urandom);
      ack_strobe = ($urandom % 4) == 0;
      status_word = 16'($urandom);
      cyc();
    end
    cfg_wr = 0; clr_wr = 0; ack_strobe = 0;
    cyc(); @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule